// File: doc/BRIEF.md
# Synchronized PWM Output Steering Unit

This block takes one PWM waveform and places it on any subset of four output pins, A through D. A pin that is not steered shows its ordinary port data bit instead. Each pin also has a tristate bit that switches its driver off. The PWM generator sits outside: the waveform and a one-cycle period-start strobe come in as inputs.

Software writes a five-bit control word. It holds four steering enables and one sync select. The written word is kept as a pending value. An effective steering register then takes that value in one of two ways. It takes it one cycle after the write, which may cut a PWM pulse short. Or it takes it on the next period-start strobe, so a pin only ever shows whole PWM periods. Steering works only in single-output mode, and two mode bits set the output polarity per pin pair.

Top module: `pwm_steer`

## Requirements
- R1: After reset, rd_data is 0 and each pin shows its port_data bit (when its tris bit is 0).
- R2: rd_data returns the last value written on wr_data. Bits [3:0] are the enables for pins D..A (bit 0 = A) and bit 4 is the sync select. This holds even before the value takes effect.
- R3: A write with bit 4 = 0 changes the pins from the second rising edge on, counting the edge that samples wr_en. After the first edge the old pattern still shows.
- R4: A write with bit 4 = 1 leaves the pins unchanged until a rising edge with period_start = 1. The pattern then applies from that edge on.
- R5: A write with bit 4 = 1 that is sampled on the same edge as period_start applies at that edge.
- R6: Steering needs out_mode = 00 and ccp_mode[3:2] = 11. In any other mode every pin shows port_data.
- R7: When all four effective enables are 0, every pin shows port_data, even in single-output mode.
- R8: ccp_mode[1] = 1 inverts the PWM on pins A and C. ccp_mode[0] = 1 inverts it on pins B and D. A value of 0 means active-high.
- R9: pin_oe[i] equals the inverse of tris[i]. pin_out[i] is 0 while tris[i] = 1.
- R10: An enabled pin in single-output mode follows pwm_in in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM waveform from the generator |
| period_start | input | 1 | One-cycle strobe at the start of each PWM period |
| out_mode | input | 2 | Output mode field; 00 selects single output |
| ccp_mode | input | 4 | PWM mode bits; [3:2]=11 selects PWM, [1:0] set polarity |
| port_data | input | 4 | Port data bits for pins D..A |
| tris | input | 4 | Per-pin driver disable, 1 = off |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Control word: sync select at [4], enables at [3:0] |
| rd_data | output | 5 | Last written control word |
| pin_out | output | 4 | Pin values for D..A |
| pin_oe | output | 4 | Pin driver enables for D..A |

## Verification
There are two ways the steering state can go wrong, and each shows up differently. A wrong pending value shows on rd_data in the cycle after the write. A wrong effective pattern shows on pin_out as soon as pwm_in and port_data differ on the affected pin. The bench therefore holds pwm_in at 1 and port_data at 0 around each commit, so a timing error on the commit edge becomes visible within one cycle. Boundary checks cover a commit one edge too early, a sync-mode commit that never waits for the strobe, and a write that coincides with the strobe.

// File: rtl/pwm_steer.sv
`timescale 1ns/1ps
module pwm_steer #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_in,
  input  logic            period_start,
  input  logic [1:0]      out_mode,
  input  logic [3:0]      ccp_mode,
  input  logic [NPIN-1:0] port_data,
  input  logic [NPIN-1:0] tris,
  input  logic            wr_en,
  input  logic [NPIN:0]   wr_data,
  output logic [NPIN:0]   rd_data,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);
  localparam int SYNC_BIT = NPIN;

  logic [NPIN:0]   pend_q;
  logic [NPIN-1:0] eff_q;
  logic            imm_q;
  logic [NPIN-1:0] pin_val;
  logic            steer_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      eff_q  <= '0;
      imm_q  <= 1'b0;
    end else begin
      if (wr_en) pend_q <= wr_data;
      imm_q <= wr_en & ~wr_data[SYNC_BIT];
      if (period_start)
        eff_q <= wr_en ? wr_data[NPIN-1:0] : pend_q[NPIN-1:0];
      else if (imm_q)
        eff_q <= pend_q[NPIN-1:0];
    end
  end

  assign steer_on = (out_mode == 2'b00) && (ccp_mode[3:2] == 2'b11);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic pol;
    assign pol        = ccp_mode[(i % 2 == 0) ? 1 : 0];
    assign pin_val[i] = (steer_on && eff_q[i]) ? (pwm_in ^ pol) : port_data[i];
  end

  assign pin_out = pin_val & ~tris;
  assign pin_oe  = ~tris;
  assign rd_data = pend_q;

  p_rdback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  p_fast_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_q && !period_start) |=> eff_q == $past(pend_q[NPIN-1:0]));

  p_hold_until_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_q && !period_start) |=> $stable(eff_q));

  p_strobe_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && wr_en) |=> eff_q == $past(wr_data[NPIN-1:0]));

  p_mode_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !steer_on |-> pin_out == (port_data & ~tris));

  p_none_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_q == '0) |-> pin_out == (port_data & ~tris));

  p_driver_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/test_pwm_steer.sv
`timescale 1ns/1ps
module test_pwm_steer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0;
  logic       period_start = 1'b0;
  logic [1:0] out_mode = 2'b00;
  logic [3:0] ccp_mode = 4'b1100;
  logic [3:0] port_data = 4'b0000;
  logic [3:0] tris = 4'b0000;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = 5'b0;
  logic [4:0] rd_data;
  logic [3:0] pin_out;
  logic [3:0] pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pwm_steer i_pwm_steer (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .period_start(period_start),
    .out_mode(out_mode), .ccp_mode(ccp_mode), .port_data(port_data), .tris(tris),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {out_mode, ccp_mode, port_data, tris, pwm_in, expected pin_out}; pins A and C enabled
  localparam logic [18:0] VEC [12] = '{
    {2'b00, 4'b1100, 4'b0000, 4'b0000, 1'b1, 4'b0101},
    {2'b00, 4'b1100, 4'b0000, 4'b0000, 1'b0, 4'b0000},
    {2'b00, 4'b1100, 4'b1111, 4'b0000, 1'b1, 4'b1111},
    {2'b00, 4'b1100, 4'b1111, 4'b0000, 1'b0, 4'b1010},
    {2'b00, 4'b1110, 4'b0000, 4'b0000, 1'b1, 4'b0000},
    {2'b00, 4'b1110, 4'b0000, 4'b0000, 1'b0, 4'b0101},
    {2'b00, 4'b1101, 4'b0000, 4'b0000, 1'b1, 4'b0101},
    {2'b01, 4'b1100, 4'b0110, 4'b0000, 1'b1, 4'b0110},
    {2'b00, 4'b1000, 4'b1001, 4'b0000, 1'b1, 4'b1001},
    {2'b00, 4'b1100, 4'b0000, 4'b0001, 1'b1, 4'b0100},
    {2'b00, 4'b1100, 4'b1111, 4'b1111, 1'b1, 4'b0000},
    {2'b11, 4'b1111, 4'b0011, 4'b0000, 1'b1, 4'b0011}
  };

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] d, input logic strobe);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; period_start = strobe;
    @(posedge clk); #1;
    wr_en = 1'b0; period_start = 1'b0;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    port_data = 4'b1010; pwm_in = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 rd_data after reset", rd_data, 5'b0);
    chk("R1 pins show port data after reset", {1'b0, pin_out}, 5'b01010);

    wr(5'b00101, 1'b0);
    cyc(1);
    for (int v = 0; v < 12; v++) begin
      @(negedge clk);
      {out_mode, ccp_mode, port_data, tris, pwm_in} = VEC[v][18:4];
      #1;
      chk($sformatf("R6/R8/R9/R10 table row %0d", v), {1'b0, pin_out}, {1'b0, VEC[v][3:0]});
      chk($sformatf("R9 oe row %0d", v), {1'b0, pin_oe}, {1'b0, ~VEC[v][8:5]});
    end

    @(negedge clk);
    out_mode = 2'b00; ccp_mode = 4'b1100; port_data = 4'b0000; tris = 4'b0000; pwm_in = 1'b1;
    wr(5'b10011, 1'b0);
    chk("R2 readback before commit", rd_data, 5'b10011);
    chk("R4 old pattern kept", {1'b0, pin_out}, 5'b00101);
    cyc(5);
    chk("R4 still waiting for strobe", {1'b0, pin_out}, 5'b00101);
    @(negedge clk); period_start = 1'b1;
    @(posedge clk); #1; period_start = 1'b0;
    chk("R4 applied at strobe", {1'b0, pin_out}, 5'b00011);

    wr(5'b00001, 1'b0);
    chk("R3 not yet after first edge", {1'b0, pin_out}, 5'b00011);
    cyc(1);
    chk("R3 applied after second edge", {1'b0, pin_out}, 5'b00001);
    chk("R2 readback immediate write", rd_data, 5'b00001);

    wr(5'b11000, 1'b1);
    chk("R5 write on strobe applies", {1'b0, pin_out}, 5'b01000);

    @(negedge clk); pwm_in = 1'b0; #1;
    chk("R10 follows pwm same cycle", {1'b0, pin_out}, 5'b00000);
    @(negedge clk); pwm_in = 1'b1;

    wr(5'b00000, 1'b0);
    cyc(1);
    @(negedge clk); port_data = 4'b0101; #1;
    chk("R7 no enables gives port data", {1'b0, pin_out}, 5'b00101);

    @(negedge clk); tris = 4'b0100; #1;
    chk("R9 tris forces pin low", {1'b0, pin_out}, 5'b00001);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule